// File: doc/BRIEF.md
# Volume envelope unit

This block sets the 4-bit loudness of one sound voice and ramps it up or down over time. Software writes one configuration byte that holds three fields: a starting volume, a ramp direction and a step period. Each time the frame sequencer sends an envelope tick, an internal timer counts down. When the timer runs out, it reloads from the period and the volume moves one step in the chosen direction. The volume stops at the top and bottom of its range.

A trigger restarts the envelope. It copies the starting volume into the running volume and loads the timer from the period. The block also decides whether the voice's DAC is powered, using the upper five configuration bits. The byte last written can be read back unchanged. A power-off input clears every register in the unit.

Top module: `vol_env`

## Requirements
- R1: While reset is asserted, and in the cycle after a clock edge with `pwr_off` high, `volume`, `rd_data` and `dac_en` are all 0. `pwr_off` takes priority over a write, a trigger and a tick in the same cycle.
- R2: After a clock edge with `wr_en` high and no `pwr_off`, `rd_data` equals `wr_data` exactly, with all 8 bits.
- R3: `dac_en` is 1 exactly when at least one of `rd_data` bits 7 to 3 is 1. Bits 7-4 are the starting volume and bit 3 is the direction. A value of 0x08 therefore enables the DAC and 0x07 does not.
- R4: After a clock edge with `trigger` high, `volume` equals bits 7-4 of the stored byte, and the timer is loaded from bits 2-0. An `env_tick` in the same cycle has no effect.
- R5: While the stored period (bits 2-0) is 0, envelope ticks leave `volume` unchanged.
- R6: With a nonzero period P, each tick first decrements a nonzero timer. When the timer is 0 after that step, it reloads to P and the volume moves one step. After a trigger, the first step therefore comes on the P-th tick, and the next one P ticks later.
- R7: When bit 3 is 1 the step adds 1, and the volume stays at 15 once it gets there. When bit 3 is 0 the step subtracts 1, and the volume stays at 0. The volume never wraps.
- R8: A configuration write never changes `volume` by itself. The new starting volume takes effect only at the next trigger. The new period and direction govern later ticks.
- R9: When a write and a trigger happen in the same cycle, the trigger uses the byte stored before that write, and `rd_data` then shows the new byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_off | input | 1 | Synchronous clear of all envelope state |
| wr_en | input | 1 | Write strobe for the configuration byte |
| wr_data | input | 8 | Configuration byte: [7:4] start volume, [3] up, [2:0] period |
| trigger | input | 1 | Restart the envelope |
| env_tick | input | 1 | Envelope clock from the frame sequencer |
| volume | output | 4 | Current volume |
| dac_en | output | 1 | DAC power enable |
| rd_data | output | 8 | Readback of the stored configuration byte |

## Verification
`volume` and `rd_data` are registered, so any write, trigger, tick or power-off shows on them exactly one clock edge later. `dac_en` follows the stored byte with no further delay, so it becomes valid in the same cycle as `rd_data`. The bench applies each stimulus for one cycle and then samples on the next falling edge, half a period after the edge that consumed it. A behavioural model is updated on that same edge and compared with the outputs on every falling edge, in both the directed part and the random part. The directed checks work out the exact tick on which each step and each saturation should appear.

// File: rtl/vol_env.sv
module vol_env #(
  parameter int VOL_W = 4,
  parameter int PER_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pwr_off,
  input  logic                     wr_en,
  input  logic [VOL_W+PER_W:0]     wr_data,
  input  logic                     trigger,
  input  logic                     env_tick,
  output logic [VOL_W-1:0]         volume,
  output logic                     dac_en,
  output logic [VOL_W+PER_W:0]     rd_data
);
  localparam int REG_W = VOL_W + PER_W + 1;
  localparam logic [VOL_W-1:0] VOL_MAX = {VOL_W{1'b1}};

  logic [REG_W-1:0] cfg;
  logic [VOL_W-1:0] vol;
  logic [PER_W-1:0] tmr;

  logic [VOL_W-1:0] cfg_init;
  logic             cfg_up;
  logic [PER_W-1:0] cfg_per;
  logic [PER_W-1:0] tmr_dec;
  logic             fire;
  logic [VOL_W-1:0] vol_step;

  assign cfg_init = cfg[REG_W-1 -: VOL_W];
  assign cfg_up   = cfg[PER_W];
  assign cfg_per  = cfg[PER_W-1:0];
  assign tmr_dec  = (tmr != '0) ? tmr - 1'b1 : '0;
  assign fire     = (tmr_dec == '0);

  always_comb begin
    vol_step = vol;
    if (cfg_up && vol != VOL_MAX) vol_step = vol + 1'b1;
    else if (!cfg_up && vol != '0) vol_step = vol - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      vol <= '0;
      tmr <= '0;
    end else if (pwr_off) begin
      cfg <= '0;
      vol <= '0;
      tmr <= '0;
    end else begin
      if (wr_en) cfg <= wr_data;
      if (trigger) begin
        vol <= cfg_init;
        tmr <= cfg_per;
      end else if (env_tick && cfg_per != '0) begin
        if (fire) begin
          tmr <= cfg_per;
          vol <= vol_step;
        end else begin
          tmr <= tmr_dec;
        end
      end
    end
  end

  assign volume  = vol;
  assign rd_data = cfg;
  assign dac_en  = |cfg[REG_W-1:PER_W];
endmodule

// File: rtl/vol_env_chk.sv
module vol_env_chk #(
  parameter int VOL_W = 4,
  parameter int PER_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pwr_off,
  input logic                 wr_en,
  input logic [VOL_W+PER_W:0] wr_data,
  input logic                 trigger,
  input logic                 env_tick,
  input logic [VOL_W-1:0]     volume,
  input logic                 dac_en,
  input logic [VOL_W+PER_W:0] rd_data
);
  localparam logic [VOL_W-1:0] VMAX = {VOL_W{1'b1}};
  localparam logic [VOL_W-1:0] ONE  = 1;

  a_r1_power_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |=> (volume == '0 && rd_data == '0 && !dac_en));

  a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pwr_off) |=> rd_data == $past(wr_data));

  a_r4_trigger_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger && !pwr_off) |=> volume == $past(rd_data[VOL_W+PER_W -: VOL_W]));

  a_r5_period_zero_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (env_tick && !trigger && !pwr_off && rd_data[PER_W-1:0] == '0) |=> $stable(volume));

  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!trigger && !pwr_off) |=> (volume == $past(volume) ||
                                volume == $past(volume) + ONE ||
                                volume == $past(volume) - ONE));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (env_tick && !trigger && !pwr_off && rd_data[PER_W] && volume == VMAX) |=> volume == VMAX);

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (env_tick && !trigger && !pwr_off && !rd_data[PER_W] && volume == '0) |=> volume == '0);

  a_r8_write_keeps_volume: assert property (@(posedge clk) disable iff (!rst_n)
    (!trigger && !env_tick && !pwr_off) |=> $stable(volume));

  a_r3_dac_follows_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pwr_off) |=> dac_en == ($past(wr_data[VOL_W+PER_W:PER_W]) != '0));
endmodule

bind vol_env vol_env_chk #(.VOL_W(VOL_W), .PER_W(PER_W)) u_chk (.*);

// File: tb/vol_env_tb.sv
`timescale 1ns/1ps
module vol_env_tb;
  logic clk = 0, rst_n = 0, pwr_off = 0, wr_en = 0, trigger = 0, env_tick = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] volume;
  logic dac_en;
  logic [7:0] rd_data;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";
  int m_cfg = 0, m_vol = 0, m_tmr = 0;

  vol_env u_dut (.clk(clk), .rst_n(rst_n), .pwr_off(pwr_off), .wr_en(wr_en),
                 .wr_data(wr_data), .trigger(trigger), .env_tick(env_tick),
                 .volume(volume), .dac_en(dac_en), .rd_data(rd_data));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    int old;
    old = m_cfg;
    if (!rst_n || pwr_off) begin
      m_cfg = 0; m_vol = 0; m_tmr = 0;
    end else begin
      if (trigger) begin
        m_vol = old >> 4; m_tmr = old & 7;
      end else if (env_tick && (old & 7) != 0) begin
        if (m_tmr > 0) m_tmr = m_tmr - 1;
        if (m_tmr == 0) begin
          m_tmr = old & 7;
          if ((old & 8) != 0) begin if (m_vol < 15) m_vol = m_vol + 1; end
          else if (m_vol > 0) m_vol = m_vol - 1;
        end
      end
      if (wr_en) m_cfg = wr_data;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(cur_req, "model volume", volume, m_vol);
    chk(cur_req, "model readback", rd_data, m_cfg);
    chk(cur_req, "model dac_en", dac_en, ((m_cfg >> 3) != 0) ? 1 : 0);
  end

  task automatic cyc(bit w, logic [7:0] d, bit tr, bit tk, bit po);
    wr_en = w; wr_data = d; trigger = tr; env_tick = tk; pwr_off = po;
    @(negedge clk);
    wr_en = 0; trigger = 0; env_tick = 0; pwr_off = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset volume", volume, 0);
    chk("R1", "reset readback", rd_data, 0);
    chk("R1", "reset dac", dac_en, 0);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R2";
    cyc(1, 8'hF1, 0, 0, 0);
    chk("R2", "readback F1", rd_data, 8'hF1);
    chk("R8", "write leaves volume", volume, 0);
    cur_req = "R3";
    cyc(1, 8'h08, 0, 0, 0);
    chk("R3", "dac on bit3", dac_en, 1);
    cyc(1, 8'h07, 0, 0, 0);
    chk("R3", "dac off low bits", dac_en, 0);

    cur_req = "R4";
    cyc(1, 8'h71, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R4", "trigger load", volume, 7);
    cur_req = "R6";
    ticks(1);
    chk("R6", "period1 step", volume, 6);
    cur_req = "R8";
    cyc(1, 8'hF2, 0, 0, 0);
    chk("R8", "write no volume change", volume, 6);
    cur_req = "R6";
    cyc(0, 0, 1, 0, 0);
    chk("R4", "retrigger F", volume, 15);
    cyc(1, 8'h72, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R4", "retrigger 7", volume, 7);
    ticks(1);
    chk("R6", "period2 first tick", volume, 7);
    ticks(1);
    chk("R6", "period2 second tick", volume, 6);
    ticks(1);
    chk("R6", "period2 third tick", volume, 6);
    ticks(1);
    chk("R6", "period2 fourth tick", volume, 5);

    cur_req = "R7";
    cyc(1, 8'h11, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    ticks(3);
    chk("R7", "floor at 0", volume, 0);
    cyc(1, 8'hE9, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    ticks(3);
    chk("R7", "ceiling at 15", volume, 15);

    cur_req = "R5";
    cyc(1, 8'h58, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    ticks(5);
    chk("R5", "period 0 frozen", volume, 5);

    cur_req = "R4";
    cyc(1, 8'hA1, 0, 0, 0);
    cyc(0, 0, 1, 1, 0);
    chk("R4", "tick with trigger ignored", volume, 10);

    cur_req = "R9";
    cyc(1, 8'h31, 0, 0, 0);
    cyc(1, 8'h91, 1, 0, 0);
    chk("R9", "trigger uses old byte", volume, 3);
    chk("R9", "readback new byte", rd_data, 8'h91);

    cur_req = "R1";
    cyc(1, 8'hFF, 1, 1, 1);
    chk("R1", "power-off volume", volume, 0);
    chk("R1", "power-off readback", rd_data, 0);
    chk("R1", "power-off dac", dac_en, 0);

    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc(r < 8, 8'($urandom()), r >= 8 && r < 14, r >= 30, r == 99);
    end

    finish_run();
  end
endmodule